// File: doc/BRIEF.md
# Boot Mode Fetch Redirect Controller

This block decides, at every reset, whether the device comes up in boot mode, holds that decision until the next qualifying reset, and steers each memory access while boot mode is active. A boot-select pin is sampled during a hardware reset, and a low level selects boot mode. While boot mode is active, the watchdog is held off. Code fetches and data reads that fall inside a 32 KiB flash window are sent to a boot ROM instead of the user flash. The window starts at 0x000000, or at 0x010000 when the segment-1 mapping flag is set.

A software reset always ends boot mode, whatever the pin level. A hardware reset ends boot mode only if the pin is sampled high. After any reset the block gives a one-cycle restart request, and the core then fetches again from address 0x000000. When the boot ROM is configured as absent, a redirected data read is marked not valid, because its data is undefined. Accesses outside the window, and all accesses outside boot mode, go to the user flash or external bus with the address unchanged.

Top module: `boot_redirect`

## Requirements
- R1: When a clock edge sees `hw_rst_i` high and `boot_sel_pin_i` low, `boot_mode_o` is 1 from that edge on.
- R2: When a clock edge sees `hw_rst_i` high and `boot_sel_pin_i` high, `boot_mode_o` is 0 from that edge on.
- R3: When a clock edge sees `sw_rst_i` high and `hw_rst_i` low, `boot_mode_o` becomes 0, whatever the pin level.
- R4: When both resets are high at the same edge, the hardware rule wins, so a low pin gives boot mode.
- R5: `boot_mode_o` changes only at edges where a reset is high. Pin changes at other times have no effect.
- R6: `wdt_disable_o` equals `boot_mode_o` at all times.
- R7: In boot mode, with the segment-1 flag clear, a valid code fetch to 0x000000–0x007FFF sets `rom_sel_o` to 1. In that case `route_addr_o` is the offset into the window.
- R8: With the segment-1 flag set, the redirected window is 0x010000–0x017FFF, and 0x000000–0x007FFF is no longer redirected.
- R9: In boot mode, valid data reads (`acc_is_code_i` = 0) to the window are redirected in the same way as code fetches.
- R10: When not in boot mode, or when the address is outside the window, `rom_sel_o` is 0, `route_addr_o` equals `acc_addr_i`, and `data_valid_o` equals `acc_valid_i`.
- R11: With `HAS_BOOT_ROM` = 0, a redirected data read gives `data_valid_o` = 0. Redirected code fetches stay valid.
- R12: `restart_o` is 1 for exactly one cycle: the cycle after a software-reset edge, or the first cycle after `hw_rst_i` falls. That cycle asks the core to fetch from 0x000000.
- R13: While either reset input is high, `rom_sel_o` and `data_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| hw_rst_i | input | 1 | Hardware reset, synchronous, active high |
| sw_rst_i | input | 1 | Software reset request, synchronous, active high |
| boot_sel_pin_i | input | 1 | Boot-select pin, low selects boot mode |
| seg1_map_i | input | 1 | Moves the flash window to segment 1 |
| acc_valid_i | input | 1 | Access request present |
| acc_is_code_i | input | 1 | 1 = code fetch, 0 = data read |
| acc_addr_i | input | ADDR_W | Access address |
| boot_mode_o | output | 1 | Boot mode active |
| wdt_disable_o | output | 1 | Holds the watchdog off |
| rom_sel_o | output | 1 | 1 = boot ROM, 0 = user flash or external bus |
| data_valid_o | output | 1 | Returned data is defined |
| route_addr_o | output | ADDR_W | Address sent to the selected target |
| restart_o | output | 1 | One-cycle request to refetch from 0x000000 |

## Verification
Reset sequences use both pin levels. They include both resets at once and pin toggles outside reset, which separates the hardware rule, the software rule and mode hold. Accesses probe both edges of each window and the first address past it, with both segment mappings. Each probe is tried as a code fetch and as a data read, and with boot mode on and off, so that a wrong window base, size or type filter is exposed. A second instance without a boot ROM is driven with the same stimulus, which isolates the data-valid rule for redirected reads.

// File: rtl/boot_redir_pkg.sv
package boot_redir_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_USER = 2'd1,
    TGT_ROM  = 2'd2
  } target_e;

endpackage

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl (
  input  logic clk_i,
  input  logic hw_rst_i,
  input  logic sw_rst_i,
  input  logic boot_sel_pin_i,
  output logic boot_mode_o,
  output logic restart_o
);

  logic mode_q;
  logic restart_q;
  logic mode_upd;
  logic enter_boot;

  // named reset events for the assertions
  assign mode_upd   = hw_rst_i | sw_rst_i;
  assign enter_boot = hw_rst_i & ~boot_sel_pin_i;

  always_ff @(posedge clk_i) begin
    if (hw_rst_i) begin
      mode_q <= enter_boot;
    end else if (sw_rst_i) begin
      mode_q <= 1'b0;
    end
    restart_q <= mode_upd;
  end

  assign boot_mode_o = mode_q;
  assign restart_o   = restart_q & ~hw_rst_i;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    !mode_upd |=> $stable(mode_q)); // R5

  AST_SW_EXIT: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    sw_rst_i |=> !mode_q); // R3

  AST_HW_SAMPLE: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    $fell(hw_rst_i) |-> (mode_q == !$past(boot_sel_pin_i))); // R1

  AST_RESTART_PULSE: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    $fell(hw_rst_i) |-> restart_o); // R12

endmodule

// File: rtl/flash_window_dec.sv
module flash_window_dec #(
  parameter int ADDR_W    = 24,
  parameter int WIN_W     = 15,
  parameter int SEG_SHIFT = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              seg1_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] offset_o
);

  localparam int TAG_W = ADDR_W - WIN_W;

  function automatic logic [TAG_W-1:0] window_tag(input logic seg1);
    logic [TAG_W-1:0] t;
    t = '0;
    if (seg1) t = TAG_W'(1 << (SEG_SHIFT - WIN_W));
    return t;
  endfunction

  function automatic logic [ADDR_W-1:0] window_offset(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] o;
    o = '0;
    o[WIN_W-1:0] = a[WIN_W-1:0];
    return o;
  endfunction

  assign hit_o    = (addr_i[ADDR_W-1:WIN_W] == window_tag(seg1_i));
  assign offset_o = window_offset(addr_i);

endmodule

// File: rtl/access_steer.sv
module access_steer
  import boot_redir_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter bit HAS_BOOT_ROM = 1'b1
) (
  input  logic              clk_i,
  input  logic              hw_rst_i,
  input  logic              sw_rst_i,
  input  logic              boot_mode_i,
  input  logic              acc_valid_i,
  input  logic              acc_is_code_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              win_hit_i,
  input  logic [ADDR_W-1:0] win_offset_i,
  output logic              rom_sel_o,
  output logic              data_valid_o,
  output logic [ADDR_W-1:0] route_addr_o
);

  logic    in_reset;
  logic    redirect;
  logic    undefined_read;
  target_e tgt;

  assign in_reset = hw_rst_i | sw_rst_i;
  assign redirect = acc_valid_i & ~in_reset & boot_mode_i & win_hit_i;

  generate
    if (HAS_BOOT_ROM) begin : g_rom
      assign undefined_read = 1'b0;
    end else begin : g_no_rom
      assign undefined_read = redirect & ~acc_is_code_i;
    end
  endgenerate

  always_comb begin
    if (!acc_valid_i || in_reset) tgt = TGT_NONE;
    else if (redirect)            tgt = TGT_ROM;
    else                          tgt = TGT_USER;
  end

  assign rom_sel_o    = (tgt == TGT_ROM);
  assign data_valid_o = (tgt != TGT_NONE) & ~undefined_read;
  assign route_addr_o = (tgt == TGT_ROM) ? win_offset_i : acc_addr_i;

  AST_ROM_ONLY_IN_BOOT: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    rom_sel_o |-> boot_mode_i); // R10

  AST_QUIET_IN_RESET: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    sw_rst_i |-> (!rom_sel_o && !data_valid_o)); // R13

  AST_NOROM_READ: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    (!HAS_BOOT_ROM && rom_sel_o && !acc_is_code_i) |-> !data_valid_o); // R11

endmodule

// File: rtl/boot_redirect.sv
module boot_redirect #(
  parameter int ADDR_W       = 24,
  parameter int WIN_W        = 15,
  parameter int SEG_SHIFT    = 16,
  parameter bit HAS_BOOT_ROM = 1'b1
) (
  input  logic              clk_i,
  input  logic              hw_rst_i,
  input  logic              sw_rst_i,
  input  logic              boot_sel_pin_i,
  input  logic              seg1_map_i,
  input  logic              acc_valid_i,
  input  logic              acc_is_code_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              boot_mode_o,
  output logic              wdt_disable_o,
  output logic              rom_sel_o,
  output logic              data_valid_o,
  output logic [ADDR_W-1:0] route_addr_o,
  output logic              restart_o
);

  logic              boot_mode;
  logic              win_hit;
  logic [ADDR_W-1:0] win_offset;

  boot_mode_ctrl u_mode (
    .clk_i          (clk_i),
    .hw_rst_i       (hw_rst_i),
    .sw_rst_i       (sw_rst_i),
    .boot_sel_pin_i (boot_sel_pin_i),
    .boot_mode_o    (boot_mode),
    .restart_o      (restart_o)
  );

  flash_window_dec #(
    .ADDR_W    (ADDR_W),
    .WIN_W     (WIN_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_dec (
    .addr_i   (acc_addr_i),
    .seg1_i   (seg1_map_i),
    .hit_o    (win_hit),
    .offset_o (win_offset)
  );

  access_steer #(
    .ADDR_W       (ADDR_W),
    .HAS_BOOT_ROM (HAS_BOOT_ROM)
  ) u_steer (
    .clk_i         (clk_i),
    .hw_rst_i      (hw_rst_i),
    .sw_rst_i      (sw_rst_i),
    .boot_mode_i   (boot_mode),
    .acc_valid_i   (acc_valid_i),
    .acc_is_code_i (acc_is_code_i),
    .acc_addr_i    (acc_addr_i),
    .win_hit_i     (win_hit),
    .win_offset_i  (win_offset),
    .rom_sel_o     (rom_sel_o),
    .data_valid_o  (data_valid_o),
    .route_addr_o  (route_addr_o)
  );

  assign boot_mode_o   = boot_mode;
  assign wdt_disable_o = boot_mode;

  AST_WDT_OFF_IN_BOOT: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    boot_mode_o |-> wdt_disable_o); // R6

endmodule

// File: tb/boot_redirect_tb_top.sv
module boot_redirect_tb_top;

  logic        clk = 1'b0;
  logic        hw_rst = 1'b1;
  logic        sw_rst = 1'b0;
  logic        pin = 1'b0;
  logic        seg1 = 1'b0;
  logic        valid = 1'b0;
  logic        code = 1'b0;
  logic [23:0] addr = '0;

  logic        a_mode, a_wdt, a_rom, a_dv, a_rst;
  logic [23:0] a_route;
  logic        b_mode, b_wdt, b_rom, b_dv, b_rst;
  logic [23:0] b_route;

  int checks = 0;
  int errors = 0;
  bit known = 1'b0;
  bit m_mode = 1'b0;
  bit m_prev = 1'b0;

  always #2 clk = ~clk;

  boot_redirect #(.HAS_BOOT_ROM(1'b1)) dut_i (
    .clk_i(clk), .hw_rst_i(hw_rst), .sw_rst_i(sw_rst), .boot_sel_pin_i(pin),
    .seg1_map_i(seg1), .acc_valid_i(valid), .acc_is_code_i(code), .acc_addr_i(addr),
    .boot_mode_o(a_mode), .wdt_disable_o(a_wdt), .rom_sel_o(a_rom),
    .data_valid_o(a_dv), .route_addr_o(a_route), .restart_o(a_rst));

  boot_redirect #(.HAS_BOOT_ROM(1'b0)) dut_norom_i (
    .clk_i(clk), .hw_rst_i(hw_rst), .sw_rst_i(sw_rst), .boot_sel_pin_i(pin),
    .seg1_map_i(seg1), .acc_valid_i(valid), .acc_is_code_i(code), .acc_addr_i(addr),
    .boot_mode_o(b_mode), .wdt_disable_o(b_wdt), .rom_sel_o(b_rom),
    .data_valid_o(b_dv), .route_addr_o(b_route), .restart_o(b_rst));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit h, bit s, bit p, bit sg, bit v, bit c, logic [23:0] a);
    int base;
    bit inwin, e_rom, e_dv_a, e_dv_b;
    int e_route;
    @(negedge clk);
    hw_rst = h; sw_rst = s; pin = p; seg1 = sg; valid = v; code = c; addr = a;
    #1;
    base    = sg ? 32'h10000 : 32'h0;
    inwin   = (int'(a) >= base) && (int'(a) < base + 32'h8000);
    e_rom   = v && !h && !s && m_mode && inwin;
    e_route = e_rom ? int'(a) - base : int'(a);
    e_dv_a  = v && !h && !s;
    e_dv_b  = e_dv_a && !(e_rom && !c);
    if (known) begin
      chk(tag, "boot_mode", 32'(a_mode), 32'(m_mode));
      chk("R6", "wdt_disable", 32'(a_wdt), 32'(m_mode));
      chk("R12", "restart", 32'(a_rst), 32'(m_prev && !h));
      chk(tag, "norom boot_mode", 32'(b_mode), 32'(m_mode));
    end
    chk(tag, "rom_sel", 32'(a_rom), 32'(e_rom));
    chk(tag, "route_addr", 32'(a_route), 32'(e_route));
    chk(tag, "data_valid", 32'(a_dv), 32'(e_dv_a));
    chk(tag, "norom rom_sel", 32'(b_rom), 32'(e_rom));
    chk(e_rom && !c ? "R11" : tag, "norom data_valid", 32'(b_dv), 32'(e_dv_b));
    @(posedge clk);
    if (h) m_mode = !p;
    else if (s) m_mode = 1'b0;
    m_prev = h || s;
    if (h) known = 1'b1;
  endtask

  // window probes for one mapping, code and data
  task automatic probe(string tag, bit sg, bit c);
    step(tag, 0, 0, 1, sg, 1, c, sg ? 24'h010000 : 24'h000000);
    step(tag, 0, 0, 1, sg, 1, c, sg ? 24'h017FFF : 24'h007FFF);
    step(tag, 0, 0, 1, sg, 1, c, sg ? 24'h018000 : 24'h008000);
    step(tag, 0, 0, 1, sg, 1, c, sg ? 24'h000123 : 24'h010123);
    step(tag, 0, 0, 1, sg, 1, c, 24'h800040);
    step(tag, 0, 0, 1, sg, 0, c, sg ? 24'h010010 : 24'h000010);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [23:0] lfsr;
    // R13: accesses during hardware reset with pin low
    step("R13", 1, 0, 0, 0, 1, 1, 24'h000100);
    step("R13", 1, 0, 0, 0, 1, 0, 24'h000200);
    // R1: boot mode entered; R12 restart pulse here
    step("R1", 0, 0, 1, 0, 0, 1, 24'h0);
    step("R1", 0, 0, 1, 0, 0, 1, 24'h0);
    // R7 code fetches, R9 data reads, low window
    probe("R7", 0, 1);
    probe("R9", 0, 0);
    // R8 segment-1 window
    probe("R8", 1, 1);
    probe("R8", 1, 0);
    // R5 pin toggles without reset
    step("R5", 0, 0, 0, 0, 1, 1, 24'h000004);
    step("R5", 0, 0, 1, 0, 1, 1, 24'h000008);
    step("R5", 0, 0, 0, 0, 0, 1, 24'h0);
    // R4 both resets with pin low: stays in boot
    step("R4", 1, 1, 0, 0, 1, 0, 24'h000010);
    step("R4", 0, 0, 1, 0, 1, 0, 24'h000010);
    // R3 software reset with pin low exits; R13 access during it
    step("R13", 0, 1, 0, 0, 1, 1, 24'h000020);
    step("R3", 0, 0, 0, 0, 1, 1, 24'h000020);
    step("R3", 0, 0, 0, 0, 0, 1, 24'h0);
    // R10 normal mode: window not redirected
    probe("R10", 0, 1);
    probe("R10", 1, 0);
    // re-enter boot, then R2 hardware reset with pin high exits
    step("R1", 1, 0, 0, 0, 0, 0, 24'h0);
    step("R1", 0, 0, 1, 0, 1, 1, 24'h000040);
    step("R2", 1, 0, 1, 0, 1, 1, 24'h000040);
    step("R2", 0, 0, 0, 0, 1, 1, 24'h000040);
    step("R2", 0, 0, 0, 0, 1, 0, 24'h007000);
    // software reset from normal mode stays normal
    step("R3", 0, 1, 1, 0, 0, 0, 24'h0);
    step("R3", 0, 0, 1, 0, 1, 1, 24'h000000);
    // pseudo-random mix in boot mode (R10 outside window, R7 inside)
    step("R1", 1, 0, 0, 0, 0, 0, 24'h0);
    lfsr = 24'h5A3C1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      step("R10", 0, 0, lfsr[5], lfsr[3], lfsr[0], lfsr[1], {5'b0, lfsr[2], 1'b0, lfsr[16:0]});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule